// File: doc/BRIEF.md
# Reloading Down-Counter with Toggling Pulse Output

This block is a down-counting timer with a reload latch. A free-running prescaler derived from the system clock produces the count strobe, which runs at one of three rates: divide by 2, by 8 or by 16. While the timer is running, each strobe lowers the count by one. The strobe that arrives while the count already sits at zero is an underflow. That strobe restores the count from the latch, sets a sticky interrupt request flag and inverts the pulse output. The output therefore carries a square wave whose half period is (latch + 1) strobes.

Software sees a plain strobe-style register interface. One strobe writes a timer value. A second strobe writes the control fields: halt, latch-only, polarity and rate select. A third strobe clears the interrupt flag. The live count is always visible on a read port. A timer write normally loads both the latch and the count and puts the output at its starting level. With latch-only set, the write updates only the latch, so the next period can be changed without disturbing the running count or the waveform.

Top module: `reload_toggle_timer`

## Requirements
- R1: The prescaler is a free-running 4-bit counter cleared by reset that advances every clock. A count strobe occurs in each cycle in which its low 1, 3 or 4 bits are all ones, for rate-select codes 0, 1 and 2 respectively. Code 3 acts as code 2. Two strobes never come in consecutive cycles.
- R2: With latch-only at 0, a timer write loads the written value into both the latch and the count at the next edge. That edge neither counts nor underflows.
- R3: With latch-only at 1, a timer write changes only the latch, and the count continues unaffected.
- R4: While halt is 0, each count strobe lowers a non-zero count by one. While halt is 1, the count holds its value.
- R5: A count strobe that finds the count at 0x0000 while running is an underflow. It loads the count from the latch value held before that edge instead of wrapping.
- R6: Every underflow sets the interrupt flag. The flag stays set until the clear strobe. A clear strobe in the same cycle as an underflow leaves the flag set.
- R7: Every underflow inverts the pulse output.
- R8: A timer write with latch-only at 0 sets the output high when the polarity in force after that edge is 0, and low when it is 1. A write with latch-only at 1 leaves the output level unchanged.
- R9: A control write that changes the polarity bit inverts the output. If an underflow comes in the same cycle, the two inversions cancel.
- R10: Reset sets latch and count to 0xFFFF, halt to 1, latch-only and polarity to 0, rate select to divide-by-2, the output high and the flag clear.
- R11: The read port always shows the live count, never the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_wr | input | 1 | Timer value write strobe |
| tmr_wdata | input | 16 | Timer value to write |
| ctl_wr | input | 1 | Control write strobe |
| ctl_halt | input | 1 | Halt bit, 1 stops counting |
| ctl_latch_only | input | 1 | 1 makes timer writes update the latch only |
| ctl_pol | input | 1 | Output polarity bit |
| ctl_rate | input | 2 | Count rate select: 0 /2, 1 /8, 2 or 3 /16 |
| irq_clr | input | 1 | Clears the interrupt flag |
| tmr_rdata | output | 16 | Live count value |
| pulse_out | output | 1 | Toggling pulse output |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in the same cycle as an underflow. Underflows are normally separated by a full reload period, and they are tied to prescaler phase. To make the collision happen, the stimulus loads zero into both latch and count at divide-by-2 and holds the clear strobe high. An underflow then arrives every second cycle, and the flag must read set after every underflow edge. Random traffic with small reload values also mixes underflows with latch-only writes and polarity flips, and a bench model tracks the prescaler phase cycle by cycle.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   typedef enum logic [1:0] {
      RATE_DIV2   = 2'd0,
      RATE_DIV8   = 2'd1,
      RATE_DIV16  = 2'd2,
      RATE_DIV16X = 2'd3
   } rate_e;

   typedef struct packed {
      logic  halt;
      logic  latch_only;
      logic  pol;
      rate_e rate;
   } tmr_ctl_t;

   localparam tmr_ctl_t CTL_RESET = '{halt: 1'b1, latch_only: 1'b0, pol: 1'b0, rate: RATE_DIV2};

endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler
   import rtt_pkg::*;
#(
   parameter int PRE_W = 4,
   parameter int LOG_A = 1,
   parameter int LOG_B = 3,
   parameter int LOG_C = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate,
   output logic  tick
);

   localparam int NTAP = 3;
   localparam int TAP_LOG [NTAP] = '{LOG_A, LOG_B, LOG_C};

   if (LOG_A < 1 || LOG_B < LOG_A || LOG_C < LOG_B || LOG_C > PRE_W) begin : g_bad_cfg
      $error("rtt_prescaler: tap widths must rise and fit within PRE_W");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  tap;

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      assign tap[g] = &pre_q[TAP_LOG[g]-1:0];
   end

   always_comb begin
      unique case (rate)
         RATE_DIV2: tick = tap[0];
         RATE_DIV8: tick = tap[1];
         default:   tick = tap[2];
      endcase
   end

   // R1
   no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             halt,
   input  logic             wr,
   input  logic             latch_only,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             direct,
   output logic             underflow
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   if (CNT_W < 2) begin : g_bad_w
      $error("rtt_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   always_comb begin
      direct    = wr & ~latch_only;
      step      = tick & ~halt & ~direct;
      underflow = step & (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  latch_q <= ALL_ONES;
      else if (wr) latch_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= ALL_ONES;
      else if (direct)    cnt_q <= wdata;
      else if (underflow) cnt_q <= latch_q;
      else if (step)      cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;

   // R2
   direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      direct |=> cnt == $past(wdata));
   // R3
   latch_only_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && latch_only && !step) |=> $stable(cnt));
   // R4
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr) |=> $stable(cnt));
   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> cnt == $past(latch_q));

endmodule

// File: rtl/rtt_pulse_irq.sv
module rtt_pulse_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic underflow,
   input  logic direct,
   input  logic pol_cur,
   input  logic pol_next,
   input  logic irq_clr,
   output logic pulse,
   output logic irq
);

   logic pulse_q;
   logic irq_q;
   logic flip;

   assign flip = underflow ^ (pol_next ^ pol_cur);

   always_ff @(posedge clk) begin
      if (!rst_n)      pulse_q <= 1'b1;
      else if (direct) pulse_q <= ~pol_next;
      else if (flip)   pulse_q <= ~pulse_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (underflow) irq_q <= 1'b1;
      else if (irq_clr)   irq_q <= 1'b0;
   end

   assign pulse = pulse_q;
   assign irq   = irq_q;

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> irq);
   // R7
   uf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !direct && pol_next == pol_cur) |=> pulse != $past(pulse));
   // R8
   write_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      direct |=> pulse == !$past(pol_next));
   // R9
   pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!underflow && !direct && pol_next != pol_cur) |=> pulse != $past(pulse));

endmodule

// File: rtl/reload_toggle_timer.sv
module reload_toggle_timer
   import rtt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 4,
   parameter int LOG_A = 1,
   parameter int LOG_B = 3,
   parameter int LOG_C = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_wr,
   input  logic [CNT_W-1:0] tmr_wdata,
   input  logic             ctl_wr,
   input  logic             ctl_halt,
   input  logic             ctl_latch_only,
   input  logic             ctl_pol,
   input  logic [1:0]       ctl_rate,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] tmr_rdata,
   output logic             pulse_out,
   output logic             irq_flag
);

   tmr_ctl_t ctl_q;
   logic     pol_next;
   logic     tick;
   logic     direct;
   logic     underflow;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= CTL_RESET;
      else if (ctl_wr) begin
         ctl_q.halt       <= ctl_halt;
         ctl_q.latch_only <= ctl_latch_only;
         ctl_q.pol        <= ctl_pol;
         ctl_q.rate       <= rate_e'(ctl_rate);
      end
   end

   assign pol_next = ctl_wr ? ctl_pol : ctl_q.pol;

   rtt_prescaler #(.PRE_W(PRE_W), .LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .rate (ctl_q.rate),
      .tick (tick)
   );

   rtt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .halt      (ctl_q.halt),
      .wr        (tmr_wr),
      .latch_only(ctl_q.latch_only),
      .wdata     (tmr_wdata),
      .cnt       (tmr_rdata),
      .direct    (direct),
      .underflow (underflow)
   );

   rtt_pulse_irq u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .underflow(underflow),
      .direct   (direct),
      .pol_cur  (ctl_q.pol),
      .pol_next (pol_next),
      .irq_clr  (irq_clr),
      .pulse    (pulse_out),
      .irq      (irq_flag)
   );

   // R6
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !underflow) |=> !irq_flag);

endmodule

// File: tb/sim_reload_toggle_timer.sv
module sim_reload_toggle_timer;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tmr_wr = 1'b0;
   logic [W-1:0] tmr_wdata = '0;
   logic         ctl_wr = 1'b0;
   logic         ctl_halt = 1'b1;
   logic         ctl_latch_only = 1'b0;
   logic         ctl_pol = 1'b0;
   logic [1:0]   ctl_rate = 2'd0;
   logic         irq_clr = 1'b0;
   logic [W-1:0] tmr_rdata;
   logic         pulse_out;
   logic         irq_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reload_toggle_timer u0 (
      .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
      .ctl_wr(ctl_wr), .ctl_halt(ctl_halt), .ctl_latch_only(ctl_latch_only),
      .ctl_pol(ctl_pol), .ctl_rate(ctl_rate), .irq_clr(irq_clr),
      .tmr_rdata(tmr_rdata), .pulse_out(pulse_out), .irq_flag(irq_flag)
   );

   // Reference model built from the requirements
   logic [3:0]   m_pre;
   logic [W-1:0] m_latch, m_cnt;
   logic         m_halt, m_lo, m_pol, m_out, m_irq;
   logic [1:0]   m_rate;

   function automatic bit strobe_due(input logic [1:0] rate, input logic [3:0] pre);
      case (rate)
         2'd0:    return pre[0];
         2'd1:    return pre[2:0] == 3'b111;
         default: return pre == 4'hF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre <= '0; m_latch <= '1; m_cnt <= '1; m_halt <= 1'b1;
         m_lo <= 1'b0; m_pol <= 1'b0; m_rate <= 2'd0; m_out <= 1'b1; m_irq <= 1'b0;
      end else begin
         automatic bit s   = strobe_due(m_rate, m_pre);
         automatic bit d   = tmr_wr && !m_lo;
         automatic bit st  = s && !m_halt && !d;
         automatic bit uf  = st && (m_cnt == 0);
         automatic bit pn  = ctl_wr ? ctl_pol : m_pol;
         m_pre <= m_pre + 1'b1;
         if (tmr_wr) m_latch <= tmr_wdata;
         if (d) m_cnt <= tmr_wdata;
         else if (uf) m_cnt <= m_latch;
         else if (st) m_cnt <= m_cnt - 1'b1;
         if (d) m_out <= !pn;
         else m_out <= m_out ^ uf ^ (pn != m_pol);
         if (uf) m_irq <= 1'b1;
         else if (irq_clr) m_irq <= 1'b0;
         if (ctl_wr) begin
            m_halt <= ctl_halt; m_lo <= ctl_latch_only; m_pol <= ctl_pol; m_rate <= ctl_rate;
         end
      end
   end

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         check("R4 R11 count", tmr_rdata, m_cnt);
         check("R7 output", {15'd0, pulse_out}, {15'd0, m_out});
         check("R6 flag", {15'd0, irq_flag}, {15'd0, m_irq});
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
      tmr_wr = 1'b0; ctl_wr = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic set_ctl(input bit halt, input bit lo, input bit pol, input logic [1:0] rate);
      ctl_halt = halt; ctl_latch_only = lo; ctl_pol = pol; ctl_rate = rate; ctl_wr = 1'b1;
      cyc();
   endtask

   task automatic wr_tmr(input logic [W-1:0] v);
      tmr_wdata = v; tmr_wr = 1'b1;
      cyc();
   endtask

   task automatic rate_test(input logic [1:0] rate, input int expect_steps);
      logic [W-1:0] a;
      set_ctl(1'b1, 1'b0, 1'b0, rate);
      wr_tmr(16'h8000);
      set_ctl(1'b0, 1'b0, 1'b0, rate);
      a = tmr_rdata;
      for (int i = 0; i < 32; i++) cyc();
      check("R1 rate", a - tmr_rdata, W'(expect_steps));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic o;
      int seen;
      void'($urandom(32'h1F2E3D4C));
      repeat (3) cyc();
      rst_n = 1'b1;
      #1;
      // R10 reset state
      check("R10 count", tmr_rdata, 16'hFFFF);
      check("R10 output", {15'd0, pulse_out}, 16'd1);
      check("R10 flag", {15'd0, irq_flag}, 16'd0);
      cmp_en = 1'b1;

      // R2 / R8 direct write, polarity 1 then 0
      set_ctl(1'b1, 1'b0, 1'b1, 2'd0);
      wr_tmr(16'd3);
      check("R2 load", tmr_rdata, 16'd3);
      check("R8 init low", {15'd0, pulse_out}, 16'd0);
      set_ctl(1'b1, 1'b0, 1'b0, 2'd0);
      check("R9 pol flip", {15'd0, pulse_out}, 16'd1);
      wr_tmr(16'd0);
      check("R8 init high", {15'd0, pulse_out}, 16'd1);

      // R3 / R11 latch-only write leaves live count and output
      set_ctl(1'b1, 1'b1, 1'b0, 2'd0);
      wr_tmr(16'd7);
      check("R3 R11 count kept", tmr_rdata, 16'd0);
      check("R8 latch-only keeps output", {15'd0, pulse_out}, 16'd1);

      // R5 / R6 / R7 underflow reloads the new latch value
      set_ctl(1'b0, 1'b1, 1'b0, 2'd0);
      seen = 0;
      for (int i = 0; i < 8 && !irq_flag; i++) cyc();
      check("R6 flag set", {15'd0, irq_flag}, 16'd1);
      check("R5 reload", tmr_rdata, 16'd7);
      check("R7 toggled", {15'd0, pulse_out}, 16'd0);

      // R6 clear while halted
      set_ctl(1'b1, 1'b0, 1'b0, 2'd0);
      irq_clr = 1'b1;
      cyc();
      check("R6 clear", {15'd0, irq_flag}, 16'd0);

      // R6 clear colliding with underflow: zero reload at divide-by-2
      wr_tmr(16'd0);
      set_ctl(1'b0, 1'b0, 1'b0, 2'd0);
      for (int i = 0; i < 40; i++) begin
         irq_clr = 1'b1;
         cyc();
         if (irq_flag) seen++;
      end
      check("R6 underflow beats clear", W'(seen > 0), 16'd1);

      // R9 polarity flips while halted
      set_ctl(1'b1, 1'b0, 1'b0, 2'd0);
      o = pulse_out;
      set_ctl(1'b1, 1'b0, 1'b1, 2'd0);
      check("R9 flip", {15'd0, pulse_out}, {15'd0, !o});
      set_ctl(1'b1, 1'b0, 1'b0, 2'd0);
      check("R9 flip back", {15'd0, pulse_out}, {15'd0, o});

      // R1 rates
      rate_test(2'd0, 16);
      rate_test(2'd1, 4);
      rate_test(2'd2, 2);
      rate_test(2'd3, 2);

      // Random traffic, checked each cycle against the model
      for (int i = 0; i < 6000; i++) begin
         automatic int unsigned r = $urandom;
         tmr_wr = (r % 16) == 0;
         tmr_wdata = ($urandom % 4 == 0) ? W'($urandom) : W'($urandom % 12);
         ctl_wr = (r % 23) == 0;
         ctl_halt = ($urandom % 4) == 0;
         ctl_latch_only = $urandom % 2;
         ctl_pol = $urandom % 2;
         ctl_rate = 2'($urandom);
         irq_clr = (r % 7) == 0;
         cyc();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule